// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits next to a small data cache and decides whether a store-conditional may succeed. It follows a fixed set of cached lines. Each tracked line can carry a reservation, and the reservation is tagged with the ID of the requester that took it. When a memory operation completes, the cache reports it here with its kind, its line address and its requester ID. A load-linked takes a reservation. A store-conditional consumes a reservation. An ordinary write drops a reservation that its own requester holds.

The coherence side reports two events. It signals an invalidate when permission for a line is lost, and it signals a fill when a line is installed. An installed line replaces an entry picked in round-robin order. One cycle after each completion, the block returns a done strobe, a success flag and a one-bit result value for the processor. An operation on a line that is not tracked always reports success and leaves every reservation unchanged.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, done_o, success_o and result_o are low and no line is tracked.
- R2: Each cycle with op_valid_i high gives exactly one cycle of done_o on the next cycle. When done_o is low, success_o and result_o are low.
- R3: A fill of an untracked line installs it unlocked in the victim entry. Victims rotate round-robin from entry 0 over NUM_ENTRIES entries. A fill of a line already tracked changes nothing.
- R4: A load-linked (op_kind_i = 2'b00) on a tracked line locks it for op_id_i and reports success_o = 1 and result_o = 0.
- R5: A store-conditional (op_kind_i = 2'b01) on a tracked line succeeds only when the line is locked by the same ID. On success it reports success_o = 1 and result_o = 1. Otherwise it reports success_o = 0 and result_o = 0.
- R6: Every store-conditional on a tracked line clears that line's lock, whether it succeeds or fails.
- R7: An ordinary write (op_kind_i = 2'b10 or 2'b11) clears the lock on its line only when that lock is held by the same ID. It reports success_o = 1 and result_o = 0.
- R8: An invalidate clears any lock on its line. An invalidate of another line, or of an untracked line, has no effect.
- R9: An operation on an untracked line reports success_o = 1 and leaves all locks unchanged. result_o is 1 for a store-conditional and 0 for the other kinds.
- R10: An invalidate and an operation on the same line in the same cycle act as if the invalidate came first. A racing store-conditional therefore fails, and a racing load-linked leaves the line locked.
- R11: A load-linked by a second ID on a locked line moves ownership to that ID.
- R12: When a fill evicts an entry, that entry's lock is lost. The line that replaces it starts unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | A completed operation is presented |
| op_kind_i | input | 2 | 00 load-linked, 01 store-conditional, 1x ordinary write |
| op_line_i | input | LINE_W | Line address of the operation |
| op_id_i | input | ID_W | Requester ID of the operation |
| inv_valid_i | input | 1 | Coherence permission lost for a line |
| inv_line_i | input | LINE_W | Line address of the invalidate |
| fill_valid_i | input | 1 | A line is installed in the cache |
| fill_line_i | input | LINE_W | Line address of the fill |
| done_o | output | 1 | Result strobe, one cycle after the operation |
| success_o | output | 1 | Operation succeeded |
| result_o | output | 1 | Value returned to the processor (1 = store-conditional success) |

## Verification
The overlap that matters is an invalidate and a completion landing on the same line in the same cycle. The bench provokes it by driving both in one cycle, first with a store-conditional and then with a load-linked, on a line that is reserved by that same requester. The racing store-conditional must report failure. After the racing load-linked, a following store-conditional from the same requester must succeed, which shows that the invalidate was ordered before the lock was taken.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LL     = 2'b00,
    OP_SC     = 2'b01,
    OP_WR     = 2'b10,
    OP_WR_ALT = 2'b11
  } op_kind_e;
endpackage

// File: rtl/llsc_match.sv
module llsc_match #(
  parameter int N      = 4,
  parameter int LINE_W = 26
) (
  input  logic                       valid_i,
  input  logic [LINE_W-1:0]          key_i,
  input  logic [N-1:0]               present_i,
  input  logic [N-1:0][LINE_W-1:0]   lines_i,
  output logic [N-1:0]               hit_o,
  output logic                       any_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = valid_i && present_i[g] && (lines_i[g] == key_i);
  end
  assign any_o = |hit_o;
endmodule

// File: rtl/llsc_victim.sv
module llsc_victim #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [N-1:0] sel_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == IDX_W'(N-1)) ? '0 : ptr_q + 1'b1;
  end

  for (genvar g = 0; g < N; g++) begin : g_sel
    assign sel_o[g] = (ptr_q == IDX_W'(g));
  end

  assert_victim_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(sel_o));
endmodule

// File: rtl/llsc_entry.sv
module llsc_entry
  import llsc_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int ID_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_hit_i,
  input  op_kind_e          op_kind_i,
  input  logic [ID_W-1:0]   op_id_i,
  input  logic              inv_hit_i,
  input  logic              fill_i,
  input  logic [LINE_W-1:0] fill_line_i,
  output logic              present_o,
  output logic [LINE_W-1:0] line_o,
  output logic              sc_ok_o
);
  logic              present_q, present_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              locked_q, locked_d;
  logic [ID_W-1:0]   owner_q, owner_d;

  // invalidate first, then the completion, then a fill replaces the entry
  always_comb begin
    present_d = present_q;
    line_d    = line_q;
    locked_d  = locked_q;
    owner_d   = owner_q;
    if (inv_hit_i) locked_d = 1'b0;
    if (op_hit_i) begin
      unique case (op_kind_i)
        OP_LL: begin
          locked_d = 1'b1;
          owner_d  = op_id_i;
        end
        OP_SC: locked_d = 1'b0;
        default: if (locked_d && owner_d == op_id_i) locked_d = 1'b0;
      endcase
    end
    if (fill_i) begin
      present_d = 1'b1;
      line_d    = fill_line_i;
      locked_d  = 1'b0;
      owner_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      present_q <= 1'b0;
      line_q    <= '0;
      locked_q  <= 1'b0;
      owner_q   <= '0;
    end else begin
      present_q <= present_d;
      line_q    <= line_d;
      locked_q  <= locked_d;
      owner_q   <= owner_d;
    end
  end

  assign present_o = present_q;
  assign line_o    = line_q;
  assign sc_ok_o   = op_hit_i && (op_kind_i == OP_SC) && locked_q && !inv_hit_i &&
                     (owner_q == op_id_i);

  assert_sc_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_hit_i && op_kind_i == OP_SC |=> !locked_q);
  assert_inv_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_hit_i && !(op_hit_i && op_kind_i == OP_LL) |=> !locked_q);
  assert_ll_locks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_hit_i && op_kind_i == OP_LL && !fill_i |=> locked_q && owner_q == $past(op_id_i));
  assert_fill_unlocked_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> present_q && !locked_q);
  assert_lock_needs_line_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |-> present_q);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int LINE_W      = 26,
  parameter int ID_W        = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [1:0]        op_kind_i,
  input  logic [LINE_W-1:0] op_line_i,
  input  logic [ID_W-1:0]   op_id_i,
  input  logic              inv_valid_i,
  input  logic [LINE_W-1:0] inv_line_i,
  input  logic              fill_valid_i,
  input  logic [LINE_W-1:0] fill_line_i,
  output logic              done_o,
  output logic              success_o,
  output logic              result_o
);
  localparam int N = NUM_ENTRIES;

  op_kind_e                  kind;
  logic [N-1:0]              present;
  logic [N-1:0][LINE_W-1:0]  lines;
  logic [N-1:0]              op_hit, inv_hit, fill_hit, sc_ok, victim, fill_sel;
  logic                      op_any, inv_any, fill_any, install;
  logic                      success_d, result_d;
  logic                      done_q, success_q, result_q;

  assign kind = op_kind_e'(op_kind_i);

  llsc_match #(.N(N), .LINE_W(LINE_W)) u_op_match (
    .valid_i(op_valid_i), .key_i(op_line_i), .present_i(present), .lines_i(lines),
    .hit_o(op_hit), .any_o(op_any));

  llsc_match #(.N(N), .LINE_W(LINE_W)) u_inv_match (
    .valid_i(inv_valid_i), .key_i(inv_line_i), .present_i(present), .lines_i(lines),
    .hit_o(inv_hit), .any_o(inv_any));

  llsc_match #(.N(N), .LINE_W(LINE_W)) u_fill_match (
    .valid_i(fill_valid_i), .key_i(fill_line_i), .present_i(present), .lines_i(lines),
    .hit_o(fill_hit), .any_o(fill_any));

  assign install  = fill_valid_i && !fill_any;
  assign fill_sel = victim & {N{install}};

  llsc_victim #(.N(N)) u_victim (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(install), .sel_o(victim));

  for (genvar g = 0; g < N; g++) begin : g_entry
    llsc_entry #(.LINE_W(LINE_W), .ID_W(ID_W)) u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .op_hit_i   (op_hit[g]),
      .op_kind_i  (kind),
      .op_id_i    (op_id_i),
      .inv_hit_i  (inv_hit[g]),
      .fill_i     (fill_sel[g]),
      .fill_line_i(fill_line_i),
      .present_o  (present[g]),
      .line_o     (lines[g]),
      .sc_ok_o    (sc_ok[g]));
  end

  // untracked lines always report success
  assign success_d = !(kind == OP_SC && op_any) || (|sc_ok);
  assign result_d  = (kind == OP_SC) && success_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q    <= 1'b0;
      success_q <= 1'b0;
      result_q  <= 1'b0;
    end else begin
      done_q    <= op_valid_i;
      success_q <= op_valid_i && success_d;
      result_q  <= op_valid_i && result_d;
    end
  end

  assign done_o    = done_q;
  assign success_o = success_q;
  assign result_o  = result_q;

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> done_o);
  assert_quiet_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> !done_o && !success_o && !result_o);
  assert_result_success_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o |-> success_o);
  assert_unique_line_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(op_hit) && $onehot0(inv_hit) && $onehot0(fill_hit));
  assert_miss_success_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !op_any |=> success_o);
  assert_race_sc_fails_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && kind == OP_SC && op_any && inv_valid_i && inv_any &&
    inv_line_i == op_line_i |=> !success_o);
endmodule

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  localparam int LINE_W = 26;
  localparam int ID_W   = 3;
  localparam logic [1:0] K_LL = 2'b00, K_SC = 2'b01, K_WR = 2'b10, K_WR2 = 2'b11;
  localparam logic [LINE_W-1:0] LA = 26'h0000100, LB = 26'h0000240, LC = 26'h0000380,
                                LD = 26'h00004c0, LE = 26'h0000500, LZ = 26'h3ffff00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [1:0] op_kind = 2'b00;
  logic [LINE_W-1:0] op_line = '0;
  logic [ID_W-1:0] op_id = '0;
  logic inv_valid = 1'b0;
  logic [LINE_W-1:0] inv_line = '0;
  logic fill_valid = 1'b0;
  logic [LINE_W-1:0] fill_line = '0;
  logic done, success, result;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  llsc_monitor #(.NUM_ENTRIES(4), .LINE_W(LINE_W), .ID_W(ID_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .op_valid_i(op_valid), .op_kind_i(op_kind), .op_line_i(op_line), .op_id_i(op_id),
    .inv_valid_i(inv_valid), .inv_line_i(inv_line),
    .fill_valid_i(fill_valid), .fill_line_i(fill_line),
    .done_o(done), .success_o(success), .result_o(result));

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op_valid = 1'b0; inv_valid = 1'b0; fill_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic clear_inputs();
    op_valid = 1'b0; inv_valid = 1'b0; fill_valid = 1'b0;
  endtask

  // drives at a falling edge, samples the registered result one cycle later
  task automatic op(logic [1:0] k, logic [LINE_W-1:0] l, logic [ID_W-1:0] id,
                    logic es, logic er, string tag, logic with_inv = 1'b0);
    op_valid = 1'b1; op_kind = k; op_line = l; op_id = id;
    inv_valid = with_inv; inv_line = l;
    @(negedge clk);
    clear_inputs();
    chk({tag, " done"}, done, 1'b1);
    chk({tag, " success"}, success, es);
    chk({tag, " result"}, result, er);
  endtask

  task automatic fill(logic [LINE_W-1:0] l);
    fill_valid = 1'b1; fill_line = l;
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic inv(logic [LINE_W-1:0] l);
    inv_valid = 1'b1; inv_line = l;
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 done after reset", done, 1'b0);
    chk("R1 success after reset", success, 1'b0);
    chk("R1 result after reset", result, 1'b0);
    op(K_SC, LA, 3'd1, 1'b1, 1'b1, "R1 empty table SC");
    op(K_LL, LZ, 3'd1, 1'b1, 1'b0, "R9 LL untracked");
    fill(LZ);
    op(K_SC, LZ, 3'd1, 1'b0, 1'b0, "R9 untracked LL took no lock");
    op(K_WR, LE, 3'd2, 1'b1, 1'b0, "R9 write untracked");
    @(negedge clk);
    chk("R2 no strobe when idle", done, 1'b0);
    chk("R2 success low when idle", success, 1'b0);
  endtask

  task automatic t_basic();
    do_reset();
    fill(LA);
    op(K_LL, LA, 3'd1, 1'b1, 1'b0, "R4 LL tracked");
    op(K_SC, LA, 3'd1, 1'b1, 1'b1, "R5 SC same owner");
    op(K_SC, LA, 3'd1, 1'b0, 1'b0, "R6 SC after success cleared");
  endtask

  task automatic t_sc_fail();
    do_reset();
    fill(LA);
    op(K_LL, LA, 3'd1, 1'b1, 1'b0, "R4 LL");
    op(K_SC, LA, 3'd2, 1'b0, 1'b0, "R5 SC other owner fails");
    op(K_SC, LA, 3'd1, 1'b0, 1'b0, "R6 failed SC cleared lock");
  endtask

  task automatic t_write();
    do_reset();
    fill(LA);
    op(K_LL, LA, 3'd1, 1'b1, 1'b0, "R7 LL");
    op(K_WR, LA, 3'd2, 1'b1, 1'b0, "R7 write other id");
    op(K_SC, LA, 3'd1, 1'b1, 1'b1, "R7 lock kept after foreign write");
    op(K_LL, LA, 3'd1, 1'b1, 1'b0, "R7 LL again");
    op(K_WR2, LA, 3'd1, 1'b1, 1'b0, "R7 write same id");
    op(K_SC, LA, 3'd1, 1'b0, 1'b0, "R7 own write cleared lock");
  endtask

  task automatic t_inv();
    do_reset();
    fill(LA);
    fill(LB);
    op(K_LL, LA, 3'd1, 1'b1, 1'b0, "R8 LL");
    inv(LB);
    inv(LE);
    op(K_SC, LA, 3'd1, 1'b1, 1'b1, "R8 other-line invalidate no effect");
    op(K_LL, LA, 3'd1, 1'b1, 1'b0, "R8 LL again");
    inv(LA);
    op(K_SC, LA, 3'd1, 1'b0, 1'b0, "R8 invalidate cleared lock");
    op(K_LL, LA, 3'd5, 1'b1, 1'b0, "R8 LL id5");
    inv(LA);
    op(K_SC, LA, 3'd5, 1'b0, 1'b0, "R8 invalidate cleared id5 lock");
  endtask

  task automatic t_takeover();
    do_reset();
    fill(LA);
    op(K_LL, LA, 3'd1, 1'b1, 1'b0, "R11 LL id1");
    op(K_LL, LA, 3'd2, 1'b1, 1'b0, "R11 LL id2");
    op(K_SC, LA, 3'd1, 1'b0, 1'b0, "R11 old owner SC fails");
    op(K_LL, LA, 3'd1, 1'b1, 1'b0, "R11 LL id1 again");
    op(K_LL, LA, 3'd2, 1'b1, 1'b0, "R11 LL id2 again");
    op(K_SC, LA, 3'd2, 1'b1, 1'b1, "R11 new owner SC succeeds");
  endtask

  task automatic t_race();
    do_reset();
    fill(LA);
    op(K_LL, LA, 3'd1, 1'b1, 1'b0, "R10 LL");
    op(K_SC, LA, 3'd1, 1'b0, 1'b0, "R10 SC racing invalidate fails", 1'b1);
    op(K_LL, LA, 3'd1, 1'b1, 1'b0, "R10 LL racing invalidate", 1'b1);
    op(K_SC, LA, 3'd1, 1'b1, 1'b1, "R10 lock survives racing invalidate");
  endtask

  task automatic t_evict();
    do_reset();
    fill(LA); fill(LB); fill(LC); fill(LD);
    op(K_LL, LA, 3'd1, 1'b1, 1'b0, "R3 LL");
    fill(LA);
    op(K_SC, LA, 3'd1, 1'b1, 1'b1, "R3 refill of tracked line no change");
    op(K_LL, LA, 3'd1, 1'b1, 1'b0, "R12 LL before eviction");
    fill(LE);
    op(K_SC, LA, 3'd1, 1'b1, 1'b1, "R12 evicted line is untracked");
    fill(LA);
    op(K_SC, LA, 3'd1, 1'b0, 1'b0, "R12 reinstalled line unlocked");
    op(K_LL, LB, 3'd1, 1'b1, 1'b0, "R3 LL on second victim");
    op(K_SC, LB, 3'd2, 1'b1, 1'b1, "R3 entry 1 was next victim");
    op(K_LL, LC, 3'd1, 1'b1, 1'b0, "R3 LL on survivor");
    op(K_SC, LC, 3'd2, 1'b0, 1'b0, "R3 entry 2 still tracked");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_sc_fail();
    t_write();
    t_inv();
    t_takeover();
    t_race();
    t_evict();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule